// File: doc/BRIEF.md
# Expansion Memory Window Register

This block lives on a memory-expansion card attached to a CPU backplane. It holds a single 8-bit paging register that the CPU reaches with an I/O write at one address in the range $C0-$C7. A 3-bit board-number setting, normally a jumper, picks the address, so up to eight cards can share the bus and each answers only its own address.

The byte held in the register chooses which 16KB block of expansion memory appears in the CPU's 16KB bank-2 window at $8000-$BFFF. The top three bits name one of eight 512KB SRAM chips. The low five bits give the upper block address inside that chip.

The block decodes the chip number into eight active-low chip selects. It drives the block number onto the extended address lines XA14-XA18. CPU address lines A13:A0 still address the byte within the block, so offset zero of any block is seen at $8000. One card therefore reaches 8 x 32 = 256 blocks, 4MB in all. The CPU can read the register back at the same I/O address.

Top module: `exp_window_reg`

## Requirements
- R1: A register write occurs on a rising clock edge only when ioBlkSel is high, ioWr is high and ioAddrLo (A5:A0) equals {3'b000, boardId}; boardId takes any value 0-7.
- R2: While winReq is high, exactly one chip select is low: chipSelN[k] is low where k is register bits 7:5, so $00, $20, $40 … $E0 select chips 0 through 7.
- R3: xAddr[4:0] equals register bits 4:0, with bit 0 on xAddr[0] (XA14) and bit 4 on xAddr[4] (XA18).
- R4: After the value $20 is written, chip 1 is selected with block 0. After $21 is written, chip 1 is selected with block 1 (xAddr = 5'b00001).
- R5: An I/O read at the matching address returns on dataOut the last value written, in the same cycle.
- R6: While winReq is low, all eight chip selects are high.
- R7: A synchronous active-low reset clears the register to $00, which selects chip 0 and block 0.
- R8: dataOe is high only while ioBlkSel and ioRd are high and the address matches. At all other times dataOe is low and dataOut is $00.
- R9: A write has no effect on the register when the low address does not match the board number or when ioBlkSel is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| ioBlkSel | input | 1 | I/O block strobe for the $C0-$FF range |
| ioAddrLo | input | 6 | CPU address bits A5:A0 of the I/O cycle |
| ioWr | input | 1 | I/O write strobe |
| ioRd | input | 1 | I/O read strobe |
| dataIn | input | 8 | CPU data bus for writes |
| winReq | input | 1 | Memory request falling in the bank-2 window |
| boardId | input | 3 | Board-number setting |
| chipSelN | output | 8 | Active-low SRAM chip selects |
| xAddr | output | 5 | Extended address lines XA14-XA18 |
| dataOut | output | 8 | Read-back data |
| dataOe | output | 1 | Read-back output enable |

## Verification
The assertions assume that boardId is held steady while the card is in use. They also assume that ioWr and ioRd are never high together, as on a real CPU bus, and that every input is settled at the rising edge. The bench changes boardId only between sweeps, while no strobe is active. It never raises both strobes at once. It drives every input on the falling edge. Each sweep writes all 256 register values, then probes the window with winReq high and low and reads the register back. The sweep also makes writes to the other seven addresses and writes with the block strobe low, and checks that none of them has any effect.

// File: rtl/exp_window_pkg.sv
package exp_window_pkg;
  localparam int CHIP_W  = 3;
  localparam int BLK_W   = 5;
  localparam int DATA_W  = CHIP_W + BLK_W;
  localparam int IO_LO_W = 6;
  localparam int BRD_W   = 3;

  typedef struct packed {
    logic regLoad;
    logic rdEn;
    logic winEn;
  } ctlStrobes_t;
endpackage

// File: rtl/exp_window_ctrl.sv
module exp_window_ctrl
  import exp_window_pkg::*;
#(
  parameter int IoLoW = IO_LO_W,
  parameter int BrdW  = BRD_W
) (
  input  logic            ioBlkSel,
  input  logic [IoLoW-1:0] ioAddrLo,
  input  logic            ioWr,
  input  logic            ioRd,
  input  logic            winReq,
  input  logic [BrdW-1:0] boardId,
  output ctlStrobes_t     strb
);
  localparam int PadW = IoLoW - BrdW;

  logic addrHit;

  // Board answers only at the one low address chosen by its board number
  assign addrHit = ioBlkSel && (ioAddrLo == {{PadW{1'b0}}, boardId});

  always_comb begin
    strb.regLoad = addrHit && ioWr;
    strb.rdEn    = addrHit && ioRd;
    strb.winEn   = winReq;
  end
endmodule

// File: rtl/exp_window_dp.sv
module exp_window_dp
  import exp_window_pkg::*;
#(
  parameter int ChipW = CHIP_W,
  parameter int BlkW  = BLK_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobes_t             strb,
  input  logic [ChipW+BlkW-1:0]   dataIn,
  output logic [(1<<ChipW)-1:0]   chipSelN,
  output logic [BlkW-1:0]         xAddr,
  output logic [ChipW+BlkW-1:0]   dataOut,
  output logic                    dataOe
);
  localparam int DataW    = ChipW + BlkW;
  localparam int NumChips = 1 << ChipW;

  logic [DataW-1:0] pageReg;
  logic [ChipW-1:0] chipField;

  always_ff @(posedge clk) begin
    if (!rstN)
      pageReg <= '0;
    else if (strb.regLoad)
      pageReg <= dataIn;
  end

  assign chipField = pageReg[DataW-1:BlkW];
  assign xAddr     = pageReg[BlkW-1:0];

  for (genvar k = 0; k < NumChips; k++) begin : g_cs
    assign chipSelN[k] = !(strb.winEn && (chipField == ChipW'(k)));
  end

  assign dataOe  = strb.rdEn;
  assign dataOut = strb.rdEn ? pageReg : '0;
endmodule

// File: rtl/exp_window_reg.sv
module exp_window_reg
  import exp_window_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ioBlkSel,
  input  logic [5:0]   ioAddrLo,
  input  logic         ioWr,
  input  logic         ioRd,
  input  logic [7:0]   dataIn,
  input  logic         winReq,
  input  logic [2:0]   boardId,
  output logic [7:0]   chipSelN,
  output logic [4:0]   xAddr,
  output logic [7:0]   dataOut,
  output logic         dataOe
);
  ctlStrobes_t strb;

  exp_window_ctrl #(.IoLoW(IO_LO_W), .BrdW(BRD_W)) u_ctrl (
    .ioBlkSel(ioBlkSel),
    .ioAddrLo(ioAddrLo),
    .ioWr(ioWr),
    .ioRd(ioRd),
    .winReq(winReq),
    .boardId(boardId),
    .strb(strb)
  );

  exp_window_dp #(.ChipW(CHIP_W), .BlkW(BLK_W)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .dataIn(dataIn),
    .chipSelN(chipSelN),
    .xAddr(xAddr),
    .dataOut(dataOut),
    .dataOe(dataOe)
  );
endmodule

// File: rtl/exp_window_reg_checker.sv
module exp_window_reg_checker (
  input logic       clk,
  input logic       rstN,
  input logic       ioBlkSel,
  input logic [5:0] ioAddrLo,
  input logic       ioWr,
  input logic       ioRd,
  input logic [7:0] dataIn,
  input logic       winReq,
  input logic [2:0] boardId,
  input logic [7:0] chipSelN,
  input logic [4:0] xAddr,
  input logic [7:0] dataOut,
  input logic       dataOe
);
  logic hit;
  assign hit = ioBlkSel && (ioAddrLo == {3'b000, boardId});

  p_cs_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !winReq |-> (chipSelN == 8'hFF));

  p_cs_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    winReq |-> ($countones(~chipSelN) == 1));

  p_load_blk_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hit && ioWr) |=> (xAddr == $past(dataIn[4:0])));

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(hit && ioWr) |=> $stable(xAddr));

  p_oe_only_hit_r8: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (hit && ioRd));

  p_out_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == 8'h00));

  p_readback_r5: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (dataOut[4:0] == xAddr));
endmodule

bind exp_window_reg exp_window_reg_checker u_chk (
  .clk(clk), .rstN(rstN), .ioBlkSel(ioBlkSel), .ioAddrLo(ioAddrLo),
  .ioWr(ioWr), .ioRd(ioRd), .dataIn(dataIn), .winReq(winReq),
  .boardId(boardId), .chipSelN(chipSelN), .xAddr(xAddr),
  .dataOut(dataOut), .dataOe(dataOe)
);

// File: tb/exp_window_reg_tb.sv
`timescale 1ns/1ps
module exp_window_reg_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic       ioBlkSel, ioWr, ioRd, winReq;
  logic [5:0] ioAddrLo;
  logic [7:0] dataIn;
  logic [2:0] boardId;
  logic [7:0] chipSelN;
  logic [4:0] xAddr;
  logic [7:0] dataOut;
  logic       dataOe;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  exp_window_reg u_dut (
    .clk(clk), .rstN(rstN), .ioBlkSel(ioBlkSel), .ioAddrLo(ioAddrLo),
    .ioWr(ioWr), .ioRd(ioRd), .dataIn(dataIn), .winReq(winReq),
    .boardId(boardId), .chipSelN(chipSelN), .xAddr(xAddr),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic check(input string req, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic idle();
    ioBlkSel = 0; ioWr = 0; ioRd = 0; winReq = 0;
    ioAddrLo = '0; dataIn = '0;
  endtask

  task automatic ioWrite(input logic blk, input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    ioBlkSel = blk; ioAddrLo = a; dataIn = d; ioWr = 1;
    @(negedge clk);
    idle();
  endtask

  // probe window and read back; combinational outputs, register already settled
  task automatic probe(input logic [7:0] v, input string tag);
    logic [7:0] expCs;
    expCs = ~(8'h01 << v[7:5]);
    winReq = 1; #0.5;
    check({tag, " R2 cs"}, int'(chipSelN), int'(expCs));
    check({tag, " R3 xaddr"}, int'(xAddr), int'(v[4:0]));
    winReq = 0; #0.5;
    check({tag, " R6 idle"}, int'(chipSelN), 8'hFF);
    ioBlkSel = 1; ioAddrLo = {3'b000, boardId}; ioRd = 1; #0.5;
    check({tag, " R5 read"}, int'(dataOut), int'(v));
    check({tag, " R8 oe"}, int'(dataOe), 1);
    idle(); #0.5;
    check({tag, " R8 quiet"}, int'({dataOe, dataOut}), 0);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    idle();
    boardId = 3'd0;
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    probe(8'h00, "R7 reset");

    // R4 examples
    ioWrite(1, 6'd0, 8'h20);
    winReq = 1; #0.5;
    check("R4 $20 cs", int'(chipSelN), 8'hFD);
    check("R4 $20 blk", int'(xAddr), 0);
    idle();
    ioWrite(1, 6'd0, 8'h21);
    winReq = 1; #0.5;
    check("R4 $21 cs", int'(chipSelN), 8'hFD);
    check("R4 $21 blk", int'(xAddr), 1);
    idle();

    // R1 sweep over every board number and every value
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      boardId = 3'(b);
      for (int v = 0; v < 256; v++) begin
        ioWrite(1, {3'b000, 3'(b)}, 8'(v));
        probe(8'(v), "R1 sweep");
      end
      // R9: other addresses, a non-zero upper address bit and no block strobe
      for (int o = 1; o < 8; o++)
        ioWrite(1, {3'b000, 3'(b ^ o)}, 8'h5A);
      ioWrite(1, {3'b001, 3'(b)}, 8'h5A);
      ioWrite(0, {3'b000, 3'(b)}, 8'h5A);
      probe(8'hFF, "R9 ignored");
      // R7: reset mid-use returns to $00
      @(negedge clk); rstN = 0;
      @(negedge clk); rstN = 1;
      probe(8'h00, "R7 reset again");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule